// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a matrix of up to six row drive lines and five column sense lines. It advances only on enabled ticks of a slow oscillator. When a key is seen, it runs one scan event. The event is two complete passes over the rows, and in each pass every active row is driven high alone while the columns are sampled. The two pass images are compared bit for bit, so a bouncing or released key is rejected. When both passes agree and at least one key is down, the 30-bit key image is latched and the active-low interrupt flag drops.

The image then stays locked. Until the host's serial logic pulses the read-done input, no new scan starts and the image cannot change. A mode input reassigns the first one or two row lines to other duties, which leaves five or four rows for scanning. A sleep code selects how the rows idle while the block waits for a key:

- With the sleep code at zero, all active rows idle high.
- With a non-zero sleep code, only a small wake group of upper rows idles high. The oscillator enable is then granted only while a scan is running.

Top module: `keymx_scan`

## Requirements
- R1: A scan event lasts exactly 2*NROWS*SLOT_TICKS + GAP_TICKS enabled ticks (582 with the defaults). In each of the two passes, each row slot lasts SLOT_TICKS ticks, in order from row 1 to row NROWS. All rows are low during the closing GAP_TICKS ticks.
- R2: During a scan at most one row output is high at a time.
- R3: row_mode selects the rows in use. 0 uses rows 1..6, 1 uses rows 2..6, and 2 or 3 use rows 3..6. Unused rows are never driven high, and their key bits are never set.
- R4: A key at row r, column c (both counted from 1) appears as key_img bit (r-1)*NCOLS + (c-1).
- R5: When both passes match and are non-zero, key_img takes that image and irq_n goes low one clock after the final gap tick. All keys held together are recorded.
- R6: When the two passes differ, nothing is stored and irq_n stays high. If a key is still held, a new scan starts at once, and this repeats until two passes agree.
- R7: A press that has gone before the first pass samples its row gives two empty passes. Nothing is stored and the block returns to waiting.
- R8: While irq_n is low, key_img is constant and no scan starts, whatever the column inputs do.
- R9: A rd_done pulse while irq_n is low clears key_img and raises irq_n on the next clock, and scanning is allowed again. A rd_done pulse while irq_n is high has no effect.
- R10: While waiting, the active rows in the wake group are driven high. sleep_code 0 uses all rows, 1 uses row 6, 2 uses rows 5..6 and 3 uses rows 4..6. A key on a row outside the wake group starts no scan.
- R11: With sleep_code 0, osc_en is always high. With a non-zero sleep_code, osc_en is high only while a scan runs.
- R12: While rst_n is low, key_img is cleared, irq_n is high and no scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| row_mode | input | 2 | Row count select: 0 six rows, 1 five rows, 2/3 four rows |
| sleep_code | input | 2 | 0 normal, 1..3 sleep with a wake row group |
| col_in | input | NCOLS | Asynchronous column sense lines |
| rd_done | input | 1 | One-clock pulse when the host has read the key image |
| row_out | output | NROWS | Row drive levels |
| osc_en | output | 1 | Oscillator run request |
| irq_n | output | 1 | Active-low key-image-ready flag |
| key_img | output | NROWS*NCOLS | Latched key image |

## Verification
The assertions assume three things about the inputs:

- rd_done arrives as a single-clock pulse.
- SLOT_TICKS covers at least three clocks, so the two-stage column synchroniser has settled before each row is sampled.
- GAP_TICKS spans at least two clocks, so stale column levels have drained before the block waits again.

The stimulus ticks the oscillator on every clock with four-tick slots. It changes row_mode and sleep_code only while the block waits and no key is held. It changes key levels on falling clock edges, and the matrix is modelled as diode-isolated row-and-column wiring.

// File: rtl/keymx_pkg.sv
package keymx_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } kscan_state_t;

  // first row in use: the lowest one or two rows may be given away
  function automatic logic row_enabled(input logic [1:0] mode, input int r);
    int first;
    first = (mode == 2'd0) ? 0 : ((mode == 2'd1) ? 1 : 2);
    return r >= first;
  endfunction

  // idle-high wake group: all rows in normal mode, else top 1..3 rows
  function automatic logic row_wakes(input logic [1:0] code, input int r, input int nrows);
    return (code == 2'd0) || (r >= nrows - int'(code));
  endfunction

  // enabled ticks in one scan event
  function automatic int scan_len(input int nrows, input int slot, input int gap);
    return 2 * nrows * slot + gap;
  endfunction

endpackage

// File: rtl/keymx_sync.sv
module keymx_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        d_sync[i] <= 1'b0;
      end else begin
        meta_q[i] <= d_async[i];
        d_sync[i] <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/keymx_timer.sv
module keymx_timer #(
  parameter int NROWS      = 6,
  parameter int SLOT_TICKS = 48,
  parameter int GAP_TICKS  = 6,
  localparam int RW = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          start,
  output logic          busy,
  output logic          in_gap,
  output logic          pass_sel,
  output logic [RW-1:0] row_idx,
  output logic          sample_ev,
  output logic          scan_end
);
  localparam int SW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int GW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  logic [SW-1:0] slot_q;
  logic [GW-1:0] gap_q;
  logic slot_last, row_last, gap_last;

  assign slot_last = (slot_q == SW'(SLOT_TICKS - 1));
  assign row_last  = (row_idx == RW'(NROWS - 1));
  assign gap_last  = (gap_q == GW'(GAP_TICKS - 1));
  assign sample_ev = busy && adv && !in_gap && slot_last;
  assign scan_end  = busy && adv && in_gap && gap_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      in_gap   <= 1'b0;
      pass_sel <= 1'b0;
      row_idx  <= '0;
      slot_q   <= '0;
      gap_q    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      in_gap   <= 1'b0;
      pass_sel <= 1'b0;
      row_idx  <= '0;
      slot_q   <= '0;
      gap_q    <= '0;
    end else if (busy && adv) begin
      if (in_gap) begin
        if (gap_last) begin
          busy   <= 1'b0;
          in_gap <= 1'b0;
          gap_q  <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end else if (slot_last) begin
        slot_q <= '0;
        if (row_last) begin
          row_idx <= '0;
          if (pass_sel) begin
            pass_sel <= 1'b0;
            in_gap   <= 1'b1;
          end else begin
            pass_sel <= 1'b1;
          end
        end else begin
          row_idx <= row_idx + 1'b1;
        end
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/keymx_ctrl.sv
module keymx_ctrl
  import keymx_pkg::*;
#(
  parameter int NROWS = 6,
  parameter int NCOLS = 5,
  localparam int RW    = (NROWS > 1) ? $clog2(NROWS) : 1,
  localparam int NKEYS = NROWS * NCOLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       row_mode,
  input  logic [1:0]       sleep_code,
  input  logic [NCOLS-1:0] col_s,
  input  logic             rd_done,
  input  logic             in_gap,
  input  logic             pass_sel,
  input  logic [RW-1:0]    row_idx,
  input  logic             sample_ev,
  input  logic             scan_end,
  output logic             start_ev,
  output logic [NROWS-1:0] row_out,
  output logic             osc_en,
  output logic             irq_n,
  output logic [NKEYS-1:0] key_img
);
  kscan_state_t state_q;
  logic [NKEYS-1:0] img_a, img_b;
  logic [NROWS-1:0] en_rows, wake_rows, scan_row;
  logic passes_agree;

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign en_rows[r]   = row_enabled(row_mode, r);
    assign wake_rows[r] = row_wakes(sleep_code, r, NROWS);
    assign scan_row[r]  = (row_idx == RW'(r));
  end

  assign start_ev     = (state_q == ST_WAIT) && (|col_s);
  assign passes_agree = (img_a == img_b) && (|img_a);
  assign irq_n        = (state_q != ST_HOLD);
  assign osc_en       = (sleep_code == 2'd0) || (state_q == ST_SCAN);

  always_comb begin
    if (state_q == ST_SCAN) row_out = in_gap ? '0 : (scan_row & en_rows);
    else                    row_out = wake_rows & en_rows;
  end

  // pass images, one row slice per sample event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_a <= '0;
      img_b <= '0;
    end else if (start_ev) begin
      img_a <= '0;
      img_b <= '0;
    end else if (sample_ev) begin
      for (int r = 0; r < NROWS; r++) begin
        if (scan_row[r]) begin
          if (!pass_sel) img_a[r*NCOLS +: NCOLS] <= col_s & {NCOLS{en_rows[r]}};
          else           img_b[r*NCOLS +: NCOLS] <= col_s & {NCOLS{en_rows[r]}};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      key_img <= '0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (start_ev) state_q <= ST_SCAN;
        ST_SCAN: if (scan_end) begin
          if (passes_agree) begin
            key_img <= img_a;
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_HOLD: if (rd_done) begin
          key_img <= '0;
          state_q <= ST_WAIT;
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/keymx_scan.sv
module keymx_scan
  import keymx_pkg::*;
#(
  parameter int NROWS      = 6,
  parameter int NCOLS      = 5,
  parameter int SLOT_TICKS = 48,
  parameter int GAP_TICKS  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   osc_tick,
  input  logic [1:0]             row_mode,
  input  logic [1:0]             sleep_code,
  input  logic [NCOLS-1:0]       col_in,
  input  logic                   rd_done,
  output logic [NROWS-1:0]       row_out,
  output logic                   osc_en,
  output logic                   irq_n,
  output logic [NROWS*NCOLS-1:0] key_img
);
  localparam int RW = (NROWS > 1) ? $clog2(NROWS) : 1;

  logic [NCOLS-1:0] col_s;
  logic adv, start_ev, scan_busy, in_gap, pass_sel, sample_ev, scan_end;
  logic [RW-1:0] row_idx;

  assign adv = osc_tick && osc_en;

  keymx_sync #(.W(NCOLS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(col_in), .d_sync(col_s)
  );

  keymx_timer #(.NROWS(NROWS), .SLOT_TICKS(SLOT_TICKS), .GAP_TICKS(GAP_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .adv(adv), .start(start_ev),
    .busy(scan_busy), .in_gap(in_gap), .pass_sel(pass_sel),
    .row_idx(row_idx), .sample_ev(sample_ev), .scan_end(scan_end)
  );

  keymx_ctrl #(.NROWS(NROWS), .NCOLS(NCOLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .row_mode(row_mode), .sleep_code(sleep_code),
    .col_s(col_s), .rd_done(rd_done), .in_gap(in_gap), .pass_sel(pass_sel),
    .row_idx(row_idx), .sample_ev(sample_ev), .scan_end(scan_end),
    .start_ev(start_ev), .row_out(row_out), .osc_en(osc_en),
    .irq_n(irq_n), .key_img(key_img)
  );
endmodule

// File: rtl/keymx_scan_chk.sv
module keymx_scan_chk
  import keymx_pkg::*;
#(
  parameter int NROWS      = 6,
  parameter int NCOLS      = 5,
  parameter int SLOT_TICKS = 48,
  parameter int GAP_TICKS  = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   adv,
  input logic                   start_ev,
  input logic                   scan_busy,
  input logic                   in_gap,
  input logic                   scan_end,
  input logic [1:0]             row_mode,
  input logic [1:0]             sleep_code,
  input logic                   rd_done,
  input logic [NROWS-1:0]       row_out,
  input logic                   osc_en,
  input logic                   irq_n,
  input logic [NROWS*NCOLS-1:0] key_img
);
  localparam int TOTAL = scan_len(NROWS, SLOT_TICKS, GAP_TICKS);
  localparam int CW    = $clog2(TOTAL + 1) + 1;

  logic [CW-1:0] tick_cnt;
  logic [NROWS-1:0] en_rows;

  for (genvar r = 0; r < NROWS; r++) begin : g_en
    assign en_rows[r] = row_enabled(row_mode, r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tick_cnt <= '0;
    else if (start_ev)        tick_cnt <= '0;
    else if (adv && scan_busy) tick_cnt <= tick_cnt + 1'b1;
  end

  // R1
  scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |-> (tick_cnt == CW'(TOTAL - 1)));
  // R1
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy && in_gap) |-> (row_out == '0));
  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> $onehot0(row_out));
  // R3
  row_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_out & ~en_rows) == '0);
  // R5
  img_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (key_img != '0));
  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_done) |=> (!irq_n && $stable(key_img)));
  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> !start_ev);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && rd_done) |=> (irq_n && key_img == '0));
  // R11
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_code != 2'd0 && !scan_busy) |-> !osc_en);
  // R11
  osc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_code == 2'd0 || scan_busy) |-> osc_en);
endmodule

bind keymx_scan keymx_scan_chk #(
  .NROWS(NROWS), .NCOLS(NCOLS), .SLOT_TICKS(SLOT_TICKS), .GAP_TICKS(GAP_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .start_ev(start_ev),
  .scan_busy(scan_busy), .in_gap(in_gap), .scan_end(scan_end),
  .row_mode(row_mode), .sleep_code(sleep_code), .rd_done(rd_done),
  .row_out(row_out), .osc_en(osc_en), .irq_n(irq_n), .key_img(key_img)
);

// File: tb/keymx_scan_tb.sv
module keymx_scan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic [1:0] row_mode = 2'd0;
  logic [1:0] sleep_code = 2'd0;
  logic [4:0] col_in;
  logic rd_done = 1'b0;
  logic [5:0] row_out;
  logic osc_en, irq_n;
  logic [29:0] key_img;
  logic [29:0] pressed = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  keymx_scan #(.NROWS(6), .NCOLS(5), .SLOT_TICKS(4), .GAP_TICKS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .row_mode(row_mode),
    .sleep_code(sleep_code), .col_in(col_in), .rd_done(rd_done),
    .row_out(row_out), .osc_en(osc_en), .irq_n(irq_n), .key_img(key_img)
  );

  // diode-isolated matrix: a column sees a pressed key on any high row
  always_comb begin
    col_in = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++)
        if (pressed[r*5+c] && row_out[r]) col_in[c] = 1'b1;
  end

  function automatic logic [5:0] exp_rows(input int m);
    int sh;
    sh = (m == 0) ? 0 : ((m == 1) ? 1 : 2);
    return 6'(6'h3F << sh);
  endfunction

  function automatic logic [5:0] exp_wake(input int s);
    if (s == 0) return 6'h3F;
    return 6'h3F ^ 6'((1 << (6 - s)) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_irq(output bit got, input int lim);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!irq_n) begin got = 1'b1; break; end
    end
  endtask

  task automatic wait_scan(output bit got, input int lim);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (row_out == 6'b000001) begin got = 1'b1; break; end
    end
  endtask

  task automatic read_pulse();
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic clean();
    pressed = '0;
    repeat (3) @(negedge clk);
    if (!irq_n) read_pulse();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    logic [5:0] en;
    logic [29:0] expv;
    int bad;
    logic [5:0] bad_act, bad_exp;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(irq_n == 1'b1, "R12", "irq_n in reset", irq_n, 1);
    chk(key_img == '0, "R12", "key_img in reset", key_img, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(row_out == 6'h3F, "R10", "wait rows normal", row_out, 6'h3F);
    chk(osc_en == 1'b1, "R11", "osc_en normal wait", osc_en, 1);

    // R1 / R2 row sequence and interrupt timing
    pressed = 30'(1) << 16;
    wait_scan(got, 50);
    chk(got, "R1", "scan start seen", got, 1);
    bad = 0; bad_act = '0; bad_exp = '0;
    for (int k = 0; k < 52; k++) begin
      logic [5:0] e;
      if (k < 48) e = 6'(1 << ((k / 4) % 6));
      else if (k < 50) e = 6'h00;
      else e = 6'h3F;
      if (row_out != e && bad == 0) begin bad_act = row_out; bad_exp = e; end
      if (row_out != e) bad++;
      if (k == 49) chk(irq_n == 1'b1, "R1", "irq_n on last gap tick", irq_n, 1);
      if (k == 50) chk(irq_n == 1'b0, "R5", "irq_n after scan end", irq_n, 0);
      @(negedge clk);
    end
    chk(bad == 0, "R2", "row drive sequence", bad_act, bad_exp);
    chk(key_img == 30'(1) << 16, "R4", "image row4 col2", key_img, 30'(1) << 16);
    clean();

    // R3 / R4 / R5 sweep every key in every row mode
    for (int m = 0; m < 3; m++) begin
      row_mode = 2'(m);
      en = exp_rows(m);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 30; i++) begin
        pressed = 30'(1) << i;
        wait_irq(got, en[i / 5] ? 400 : 150);
        expv = en[i / 5] ? (30'(1) << i) : '0;
        if (m == 0) chk(key_img == expv, "R4", "single key image", key_img, expv);
        else        chk(key_img == expv, "R3", "masked key image", key_img, expv);
        chk(got == en[i / 5], "R3", "interrupt per row use", got, en[i / 5]);
        clean();
      end
    end

    // R5 several keys at once, six-row mode
    row_mode = 2'd0;
    repeat (4) @(negedge clk);
    expv = (30'(1) << 0) | (30'(1) << 12) | (30'(1) << 29);
    pressed = expv;
    wait_irq(got, 400);
    chk(got && key_img == expv, "R5", "multi key image", key_img, expv);
    clean();

    // R3 a disabled-row key held with an enabled one
    row_mode = 2'd1;
    repeat (4) @(negedge clk);
    pressed = (30'(1) << 0) | (30'(1) << 7);
    wait_irq(got, 400);
    chk(key_img == 30'(1) << 7, "R3", "disabled row dropped", key_img, 30'(1) << 7);
    clean();
    row_mode = 2'd0;
    repeat (4) @(negedge clk);

    // R6 bounce: key changes between passes, then retry succeeds
    pressed = 30'(1) << 15;
    wait_scan(got, 50);
    repeat (26) @(negedge clk);
    pressed = 30'(1) << 17;
    repeat (25) @(negedge clk);
    chk(irq_n == 1'b1, "R6", "mismatch not stored irq", irq_n, 1);
    chk(key_img == '0, "R6", "mismatch not stored img", key_img, 0);
    wait_irq(got, 400);
    chk(got && key_img == 30'(1) << 17, "R6", "retry image", key_img, 30'(1) << 17);
    clean();

    // R7 short press gives empty passes
    pressed = 30'(1) << 25;
    wait_scan(got, 50);
    @(negedge clk);
    pressed = '0;
    wait_irq(got, 200);
    chk(!got, "R7", "short press no irq", got, 0);
    chk(key_img == '0, "R7", "short press no image", key_img, 0);
    clean();

    // R8 lockout while holding
    pressed = 30'(1) << 3;
    wait_irq(got, 400);
    pressed = (30'(1) << 3) | (30'(1) << 20);
    repeat (300) @(negedge clk);
    chk(irq_n == 1'b0, "R8", "irq held low", irq_n, 0);
    chk(key_img == 30'(1) << 3, "R8", "image frozen", key_img, 30'(1) << 3);
    chk(row_out == 6'h3F, "R8", "no scan rows", row_out, 6'h3F);

    // R9 read with key still held: release then rescan
    read_pulse();
    chk(irq_n == 1'b1, "R9", "irq released", irq_n, 1);
    chk(key_img == '0, "R9", "image cleared", key_img, 0);
    wait_irq(got, 400);
    expv = (30'(1) << 3) | (30'(1) << 20);
    chk(got && key_img == expv, "R9", "rescan after read", key_img, expv);
    clean();

    // R9 read pulse while idle has no effect
    read_pulse();
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b1 && key_img == '0, "R9", "idle read ignored", key_img, 0);

    // R10 / R11 sleep codes
    for (int s = 1; s < 4; s++) begin
      sleep_code = 2'(s);
      repeat (3) @(negedge clk);
      chk(row_out == exp_wake(s), "R10", "wake rows", row_out, exp_wake(s));
      chk(osc_en == 1'b0, "R11", "osc stopped in sleep wait", osc_en, 0);
      pressed = 30'(1) << ((5 - s) * 5);
      wait_irq(got, 150);
      chk(!got && key_img == '0, "R10", "non-wake key ignored", got, 0);
      pressed = 30'(1) << 27;
      wait_scan(got, 50);
      chk(got && osc_en == 1'b1, "R11", "osc runs during scan", osc_en, 1);
      wait_irq(got, 400);
      chk(got && key_img == 30'(1) << 27, "R10", "wake key image", key_img, 30'(1) << 27);
      @(negedge clk);
      chk(osc_en == 1'b0, "R11", "osc stopped in sleep hold", osc_en, 0);
      clean();
    end
    sleep_code = 2'd0;
    repeat (4) @(negedge clk);

    // R12 reset clears a held image
    pressed = 30'(1) << 5;
    wait_irq(got, 400);
    pressed = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(key_img == '0 && irq_n == 1'b1, "R12", "reset clears hold", key_img, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule